// File: doc/BRIEF.md
# Two-Speed PLL Lock State Controller

This block supervises the loop filter of a line-locked PLL. It picks between a fast-acquisition coefficient set and a slow-tracking coefficient set. For every input line it counts the phase-detector error events and compares the count with a programmable tolerance when the line-end strobe arrives.

While the loop is acquiring, the block counts consecutive good lines. It moves to the slow, locked state only after a programmed run of such lines. Once it is locked, a single bad line sends it back to the fast state on that same line end. The selected coefficient word drives the filter directly, so filter behaviour follows the state with no further glue logic.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After a synchronous reset, `mode_slow` is 0, `locked` is 0 and `coef_sel` equals `fast_coef`.
- R2: A line's error count covers every cycle with `phase_err` high since the previous line end, including the cycle in which `line_end` is high. The line is bad when that count is strictly greater than `err_tol`. Otherwise it is good.
- R3: The per-line error count restarts from zero after each `line_end`, so errors never carry into the next line.
- R4: The per-line error count saturates at 2^ERR_W-1 and does not wrap.
- R5: In the fast state, the block enters the slow state on the line end that completes `lines_needed` consecutive good lines, and not earlier. The new state is visible right after the clock edge that samples that `line_end`.
- R6: A `lines_needed` value of 0 behaves as 1, so a single good line locks the block.
- R7: A bad line in the fast state resets the good-line run to zero, so a full new run is required. The run also starts from zero on every entry into the fast state.
- R8: In the slow state, a bad line returns the block to the fast state on that line's end.
- R9: In the slow state, good lines keep the block in the slow state.
- R10: `locked` equals `mode_slow`. `coef_sel` equals `slow_coef` in the slow state and `fast_coef` in the fast state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_end | input | 1 | One-cycle strobe marking the end of an input line |
| phase_err | input | 1 | One-cycle strobe per phase-detector error event |
| err_tol | input | ERR_W | Highest error count a line may have and still be good |
| lines_needed | input | LINE_W | Consecutive good lines required to lock (0 acts as 1) |
| fast_coef | input | COEF_W | Coefficient word used in the fast state |
| slow_coef | input | COEF_W | Coefficient word used in the slow state |
| mode_slow | output | 1 | Current state: 0 fast, 1 slow |
| locked | output | 1 | High only in the slow state |
| coef_sel | output | COEF_W | Coefficient word for the loop filter |

## Verification
The bench builds the block with ERR_W=3 and LINE_W=4, leaving COEF_W at 16. With a three-bit error counter, a line of 20 error pulses drives the counter into saturation. Against a tolerance of 6, the saturated value of 7 marks the line bad, while a wrapping counter would read 4 and call it good. The narrow line-count field also keeps the lock runs short, and it makes the zero-count case cheap to reach from the fast state.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    typedef enum logic {
        MODE_FAST = 1'b0,
        MODE_SLOW = 1'b1
    } lock_mode_e;

    // Result of one completed line, valid in the cycle of the line-end strobe
    typedef struct packed {
        logic done;
        logic bad;
    } line_verdict_t;

    function automatic logic verdict_good(input line_verdict_t v);
        return v.done && !v.bad;
    endfunction

endpackage

// File: rtl/line_err_counter.sv
module line_err_counter
    import pll_lock_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_end,
    input  logic             phase_err,
    input  logic [ERR_W-1:0] err_tol,
    output line_verdict_t    verdict
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic [ERR_W-1:0] cnt_q;
    logic [ERR_W-1:0] cnt_inc;

    // Saturating increment; includes an error arriving with the line end
    always_comb begin
        cnt_inc = cnt_q;
        if (phase_err && (cnt_q != CNT_MAX))
            cnt_inc = cnt_q + 1'b1;
    end

    always_comb begin
        verdict.done = line_end;
        verdict.bad  = line_end && (cnt_inc > err_tol);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (line_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_inc;
    end

    // R3: counter restarts after every line end
    assert_line_clear_R3: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (cnt_q == '0));

    // R4: a full counter stays full until the line ends
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !line_end) |=> (cnt_q == CNT_MAX));

    // R4: within a line the count never decreases
    assert_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/lock_mode_fsm.sv
module lock_mode_fsm
    import pll_lock_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  line_verdict_t     verdict,
    input  logic [LINE_W-1:0] lines_needed,
    output lock_mode_e        mode
);
    localparam int RUN_W = LINE_W + 1;

    lock_mode_e        mode_q;
    logic [LINE_W-1:0] run_q;
    logic [LINE_W-1:0] need_eff;
    logic [RUN_W-1:0]  run_plus;
    logic              line_good;

    always_comb begin
        need_eff  = (lines_needed == '0) ? LINE_W'(1) : lines_needed;
        run_plus  = {1'b0, run_q} + RUN_W'(1);
        line_good = verdict_good(verdict);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FAST;
            run_q  <= '0;
        end else begin
            case (mode_q)
                MODE_FAST: begin
                    if (verdict.bad) begin
                        run_q <= '0;
                    end else if (line_good) begin
                        if (run_plus >= {1'b0, need_eff}) begin
                            mode_q <= MODE_SLOW;
                            run_q  <= '0;
                        end else begin
                            run_q <= run_plus[LINE_W-1:0];
                        end
                    end
                end
                default: begin
                    if (verdict.bad) begin
                        mode_q <= MODE_FAST;
                        run_q  <= '0;
                    end
                end
            endcase
        end
    end

    assign mode = mode_q;

    // R1: reset forces the fast state with an empty run
    assert_reset_fast_R1: assert property (@(posedge clk)
        rst |=> (mode_q == MODE_FAST && run_q == '0));

    // R8: a bad line while slow drops back to fast
    assert_bad_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SLOW && verdict.bad) |=> (mode_q == MODE_FAST));

    // R5: leaving fast only happens on a good line end
    assert_lock_on_good_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FAST && !line_good) |=> (mode_q == MODE_FAST));

    // R9: a line that is not bad keeps the slow state
    assert_hold_slow_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SLOW && !verdict.bad) |=> (mode_q == MODE_SLOW));

    // R7: a bad line empties the good-line run
    assert_run_clear_R7: assert property (@(posedge clk) disable iff (rst)
        verdict.bad |=> (run_q == '0));

endmodule

// File: rtl/coef_select.sv
module coef_select
    import pll_lock_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  lock_mode_e        mode,
    input  logic [COEF_W-1:0] fast_coef,
    input  logic [COEF_W-1:0] slow_coef,
    output logic              locked,
    output logic [COEF_W-1:0] coef_sel
);
    always_comb begin
        locked   = (mode == MODE_SLOW);
        coef_sel = (mode == MODE_SLOW) ? slow_coef : fast_coef;
    end
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
    import pll_lock_pkg::*;
#(
    parameter int ERR_W  = 8,
    parameter int LINE_W = 8,
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic              phase_err,
    input  logic [ERR_W-1:0]  err_tol,
    input  logic [LINE_W-1:0] lines_needed,
    input  logic [COEF_W-1:0] fast_coef,
    input  logic [COEF_W-1:0] slow_coef,
    output logic              mode_slow,
    output logic              locked,
    output logic [COEF_W-1:0] coef_sel
);
    line_verdict_t verdict;
    lock_mode_e    mode;

    line_err_counter #(.ERR_W(ERR_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .line_end  (line_end),
        .phase_err (phase_err),
        .err_tol   (err_tol),
        .verdict   (verdict)
    );

    lock_mode_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .verdict      (verdict),
        .lines_needed (lines_needed),
        .mode         (mode)
    );

    coef_select #(.COEF_W(COEF_W)) u_sel (
        .mode      (mode),
        .fast_coef (fast_coef),
        .slow_coef (slow_coef),
        .locked    (locked),
        .coef_sel  (coef_sel)
    );

    assign mode_slow = (mode == MODE_SLOW);

    // R10: the coefficient output only changes along with the state
    assert_coef_follows_R10: assert property (@(posedge clk) disable iff (rst)
        ($stable(mode_slow) && $stable(fast_coef) && $stable(slow_coef)) |-> $stable(coef_sel));

endmodule

// File: tb/pll_lock_ctrl_test.sv
module pll_lock_ctrl_test;
    localparam int ERR_W  = 3;
    localparam int LINE_W = 4;
    localparam int COEF_W = 16;
    localparam logic [COEF_W-1:0] FAST_C = 16'hA5A5;
    localparam logic [COEF_W-1:0] SLOW_C = 16'h3C3C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              line_end = 1'b0;
    logic              phase_err = 1'b0;
    logic [ERR_W-1:0]  err_tol = '0;
    logic [LINE_W-1:0] lines_needed = '0;
    logic [COEF_W-1:0] fast_coef = FAST_C;
    logic [COEF_W-1:0] slow_coef = SLOW_C;
    logic              mode_slow;
    logic              locked;
    logic [COEF_W-1:0] coef_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pll_lock_ctrl #(.ERR_W(ERR_W), .LINE_W(LINE_W), .COEF_W(COEF_W)) uut (
        .clk(clk), .rst(rst), .line_end(line_end), .phase_err(phase_err),
        .err_tol(err_tol), .lines_needed(lines_needed),
        .fast_coef(fast_coef), .slow_coef(slow_coef),
        .mode_slow(mode_slow), .locked(locked), .coef_sel(coef_sel)
    );

    task automatic check(input string req, input longint actual, input longint expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    // Full state check: mode, locked flag and selected coefficients
    task automatic check_state(input string req, input bit slow);
        check(req, mode_slow, slow);
        check(req, locked, slow);
        check(req, coef_sel, slow ? SLOW_C : FAST_C);
    endtask

    // One line: n error pulses, then the line-end cycle (optionally with an error)
    // Returns at the negedge right after the edge that sampled line_end
    task automatic send_line(input int n, input bit err_at_end);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            phase_err = 1'b1;
            line_end  = 1'b0;
        end
        @(negedge clk);
        phase_err = err_at_end;
        line_end  = 1'b1;
        @(negedge clk);
        phase_err = 1'b0;
        line_end  = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset();
        do_reset();
        check_state("R1", 1'b0);
    endtask

    task automatic test_basic_lock();
        do_reset();
        err_tol = 3'd2;
        lines_needed = 4'd3;
        send_line(2, 1'b0);          // count equal to tolerance is good (R2)
        check_state("R5", 1'b0);
        send_line(2, 1'b0);
        check_state("R5", 1'b0);
        send_line(1, 1'b0);
        check_state("R5", 1'b1);     // third good line locks
    endtask

    task automatic test_slow_hold_and_exit();
        send_line(0, 1'b0);
        check_state("R9", 1'b1);
        send_line(2, 1'b0);
        check_state("R9", 1'b1);
        send_line(3, 1'b0);          // above tolerance
        check_state("R8", 1'b0);
        check("R10", coef_sel, FAST_C);
    endtask

    task automatic test_run_reset();
        // Entered fast above: run starts empty (R7)
        send_line(0, 1'b0);
        send_line(0, 1'b0);
        send_line(5, 1'b0);          // bad line breaks the run
        send_line(0, 1'b0);
        send_line(0, 1'b0);
        check_state("R7", 1'b0);
        send_line(0, 1'b0);
        check_state("R7", 1'b1);
    endtask

    task automatic test_end_pulse_counts();
        send_line(2, 1'b1);          // 2 + 1 = 3 > 2
        check_state("R2", 1'b0);
    endtask

    task automatic test_clear_between_lines();
        lines_needed = 4'd1;
        send_line(0, 1'b0);
        check_state("R3", 1'b1);
        send_line(2, 1'b0);
        send_line(2, 1'b0);          // would total 4 without clearing
        check_state("R3", 1'b1);
    endtask

    task automatic test_saturation();
        err_tol = 3'd6;
        send_line(20, 1'b0);         // saturates at 7 > 6; wrap gives 4
        check_state("R4", 1'b0);
    endtask

    task automatic test_zero_need();
        lines_needed = 4'd0;
        send_line(20, 1'b0);         // bad line in fast: stays fast
        check_state("R6", 1'b0);
        send_line(1, 1'b0);
        check_state("R6", 1'b1);
    endtask

    initial begin
        test_reset();
        test_basic_lock();
        test_slow_hold_and_exit();
        test_run_reset();
        test_end_pulse_counts();
        test_clear_between_lines();
        test_saturation();
        test_zero_need();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule